// File: doc/BRIEF.md
# External Memory Bus Interface Unit

This unit sits between a processor core and the external memory and I/O devices on a board. The core issues one read or write at a time, each tagged with one of three address spaces: program, data or I/O. The unit runs the matching external bus cycle. It places the address on a shared 16-bit address bus and pulls low the one select line that names the space. It sets the direction lines, drops the strobe and, for writes, drops the write enable while it drives the data bus. While the external ready line is low, it stretches the cycle one clock at a time.

Every pin that can float is modelled as a drive value plus an output enable. The float rules differ by pin group. The address bus floats only under the emulation float input. The data bus floats whenever no write data is being driven, and also during reset, power-down or emulation float. The selects, strobe and read/write line float in reset, power-down and emulation float. Write enable and the inverted direction line float only in reset and emulation float.

Top module: `ext_bus_unit`

## Requirements
- R1: The address output carries the latched request address throughout the bus cycle for all three spaces, and it does not change while the strobe is low.
- R2: Space code 0 selects program space, code 1 selects data space and code 2 selects I/O space. All three active-low selects are high while idle. During a cycle, only the select matching the request is low.
- R3: With ready high, a cycle takes exactly two clocks. The first is a setup clock with address, select and direction valid and strobe high. The second is a strobe clock with strobe low. The cycle starts on the clock edge that accepts the request.
- R4: Each clock edge that samples ready low during the strobe clock adds one more strobe clock. The cycle ends on the first edge that samples ready high.
- R5: The read/write line is high while idle and for reads, and low from setup to the end of a write cycle. The inverted read/write output is always its logical complement.
- R6: The active-low strobe is low only during the strobe clocks of a cycle.
- R7: On a write, write enable goes low together with the start of data-bus drive in the first strobe clock. It returns high when the cycle ends. The data output carries the write data, and data-bus drive stays on for one clock after write enable rises.
- R8: The data output enable is low during reads, while idle (outside the write tail), during reset, in power-down and while the float input is low.
- R9: The address output enable is low only while the float input is low. In power-down, the address output keeps its last value.
- R10: The selects, strobe and read/write outputs share one enable, which is low during reset, in power-down or while the float input is low. Write enable and the inverted read/write output share a second enable, which is low during reset or while the float input is low.
- R11: On a read, the data input is captured on the edge that ends the cycle. It is returned with a read-valid pulse exactly one clock long.
- R12: Busy is high from the accepting edge until the cycle ends, and also during power-down. A request is accepted only while busy is low. Request inputs that change during a cycle have no effect on it.
- R13: A request with space code 3 is ignored. No cycle starts and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down mode |
| float_n | input | 1 | Emulation float, active low |
| req_valid | input | 1 | Core request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 program, 1 data, 2 I/O, 3 ignored |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Unit cannot accept a request |
| rd_valid | output | 1 | One-clock read-return pulse |
| rd_data | output | 16 | Captured read data |
| addr_o | output | 16 | External address value |
| addr_oe | output | 1 | Address bus drive enable |
| data_o | output | 16 | External data drive value |
| data_oe | output | 1 | Data bus drive enable |
| data_i | input | 16 | External data bus sampled value |
| ready_i | input | 1 | External ready |
| prog_sel_n | output | 1 | Program space select, active low |
| data_sel_n | output | 1 | Data space select, active low |
| io_sel_n | output | 1 | I/O space select, active low |
| strobe_n | output | 1 | Bus cycle strobe, active low |
| rw_o | output | 1 | High = read, low = write |
| ctl_oe | output | 1 | Enable for selects, strobe, rw_o |
| wr_o | output | 1 | Inverted rw_o |
| we_n | output | 1 | Write enable, active low |
| we_oe | output | 1 | Enable for we_n and wr_o |

## Verification
The bench checks each phase of the bus cycle with zero, one and several wait states. A unit that samples ready at the wrong edge would shorten or lengthen the strobe by one clock, and a missing setup clock would drop the strobe too early. It changes the request inputs mid-cycle and offers space code 3, where a unit that does not latch its request, or that decodes the unused code, would move the address or start a cycle. It drives reset, power-down and float one at a time and checks each output enable group. A design that treats the groups alike would float the address in power-down or keep write enable driven in reset. It also confirms that data drive outlasts the write-enable rise by one clock.

// File: rtl/ebu_pkg.sv
package ebu_pkg;
    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2
    } phase_e;

    localparam int NUM_SPACES = 3;
endpackage

// File: rtl/ebu_seq.sv
module ebu_seq
    import ebu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_space,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready_i,
    input  logic [DW-1:0] data_i,
    output phase_e        phase,
    output space_e        cur_space,
    output logic          cur_write,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          wr_tail,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        phase_e        phase;
        space_e        space;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rd_valid;
        logic          wr_tail;
    } seq_t;

    seq_t st_d, st_q;
    logic accept;

    assign busy   = (st_q.phase != PH_IDLE) || pwr_down;
    assign accept = req_valid && !busy && (space_e'(req_space) != SP_NONE);

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.wr_tail  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.phase = PH_SETUP;
                    st_d.space = space_e'(req_space);
                    st_d.write = req_write;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                end
            end
            PH_SETUP: st_d.phase = PH_STROBE;
            PH_STROBE: begin
                if (ready_i) begin
                    st_d.phase = PH_IDLE;
                    if (st_q.write) begin
                        st_d.wr_tail = 1'b1;
                    end else begin
                        st_d.rdata    = data_i;
                        st_d.rd_valid = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, space: SP_NONE, write: 1'b0,
                      addr: '0, wdata: '0, rdata: '0,
                      rd_valid: 1'b0, wr_tail: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign cur_space = st_q.space;
    assign cur_write = st_q.write;
    assign addr_q    = st_q.addr;
    assign wdata_q   = st_q.wdata;
    assign wr_tail   = st_q.wr_tail;
    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rdata;
endmodule

// File: rtl/ebu_space_dec.sv
module ebu_space_dec
    import ebu_pkg::*;
#(
    parameter int N = NUM_SPACES
) (
    input  logic         active,
    input  space_e       space,
    output logic [N-1:0] sel_n
);
    for (genvar g = 0; g < N; g++) begin : g_sel
        assign sel_n[g] = !(active && (int'(space) == g));
    end
endmodule

// File: rtl/ebu_pad_ctl.sv
module ebu_pad_ctl
    import ebu_pkg::*;
(
    input  logic   rst_n,
    input  logic   pwr_down,
    input  logic   float_n,
    input  phase_e phase,
    input  logic   cur_write,
    input  logic   wr_tail,
    output logic   strobe_n,
    output logic   rw_o,
    output logic   wr_o,
    output logic   we_n,
    output logic   ctl_oe,
    output logic   we_oe,
    output logic   addr_oe,
    output logic   data_oe
);
    logic in_cycle, wr_strobe;

    assign in_cycle  = (phase != PH_IDLE);
    assign wr_strobe = cur_write && (phase == PH_STROBE);

    assign strobe_n = (phase != PH_STROBE);
    assign rw_o     = !(cur_write && in_cycle);
    assign wr_o     = !rw_o;
    assign we_n     = !wr_strobe;

    assign addr_oe = float_n;
    assign ctl_oe  = rst_n && !pwr_down && float_n;
    assign we_oe   = rst_n && float_n;
    assign data_oe = (wr_strobe || wr_tail) && rst_n && !pwr_down && float_n;
endmodule

// File: rtl/ext_bus_unit.sv
module ext_bus_unit
    import ebu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          float_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_space,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    input  logic [DW-1:0] data_i,
    input  logic          ready_i,
    output logic          prog_sel_n,
    output logic          data_sel_n,
    output logic          io_sel_n,
    output logic          strobe_n,
    output logic          rw_o,
    output logic          ctl_oe,
    output logic          wr_o,
    output logic          we_n,
    output logic          we_oe
);
    phase_e                phase;
    space_e                cur_space;
    logic                  cur_write;
    logic                  wr_tail;
    logic [NUM_SPACES-1:0] sel_vec_n;

    ebu_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ready_i(ready_i), .data_i(data_i),
        .phase(phase), .cur_space(cur_space), .cur_write(cur_write),
        .addr_q(addr_o), .wdata_q(data_o), .wr_tail(wr_tail),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    ebu_space_dec #(.N(NUM_SPACES)) u_dec (
        .active(phase != PH_IDLE),
        .space(cur_space),
        .sel_n(sel_vec_n)
    );

    assign prog_sel_n = sel_vec_n[0];
    assign data_sel_n = sel_vec_n[1];
    assign io_sel_n   = sel_vec_n[2];

    ebu_pad_ctl u_pad (
        .rst_n(rst_n), .pwr_down(pwr_down), .float_n(float_n),
        .phase(phase), .cur_write(cur_write), .wr_tail(wr_tail),
        .strobe_n(strobe_n), .rw_o(rw_o), .wr_o(wr_o), .we_n(we_n),
        .ctl_oe(ctl_oe), .we_oe(we_oe), .addr_oe(addr_oe), .data_oe(data_oe)
    );
endmodule

// File: rtl/ebu_checker.sv
module ebu_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_down,
    input logic          float_n,
    input logic          busy,
    input logic          rd_valid,
    input logic [AW-1:0] addr_o,
    input logic          data_oe,
    input logic          ready_i,
    input logic          prog_sel_n,
    input logic          data_sel_n,
    input logic          io_sel_n,
    input logic          strobe_n,
    input logic          rw_o,
    input logic          we_n
);
    logic [2:0] sels_n;
    assign sels_n = {prog_sel_n, data_sel_n, io_sel_n};

    assert_one_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sels_n) <= 1);

    assert_idle_sels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sels_n == 3'b111));

    assert_wait_extends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !ready_i) |=> !strobe_n);

    assert_strobe_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> $past(sels_n != 3'b111));

    assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> $stable(addr_o));

    assert_we_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!strobe_n && !rw_o));

    assert_data_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (float_n && !pwr_down));

    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind ext_bus_unit ebu_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .float_n(float_n),
    .busy(busy), .rd_valid(rd_valid), .addr_o(addr_o), .data_oe(data_oe),
    .ready_i(ready_i), .prog_sel_n(prog_sel_n), .data_sel_n(data_sel_n),
    .io_sel_n(io_sel_n), .strobe_n(strobe_n), .rw_o(rw_o), .we_n(we_n)
);

// File: tb/sim_ext_bus_unit.sv
`timescale 1ns/1ps
module sim_ext_bus_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        float_n = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] data_i = '0;
    logic        ready_i = 1'b1;
    logic        busy, rd_valid, addr_oe, data_oe;
    logic [15:0] rd_data, addr_o, data_o;
    logic        prog_sel_n, data_sel_n, io_sel_n, strobe_n, rw_o, ctl_oe;
    logic        wr_o, we_n, we_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ext_bus_unit u0 (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .float_n(float_n),
        .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o), .data_oe(data_oe),
        .data_i(data_i), .ready_i(ready_i),
        .prog_sel_n(prog_sel_n), .data_sel_n(data_sel_n), .io_sel_n(io_sel_n),
        .strobe_n(strobe_n), .rw_o(rw_o), .ctl_oe(ctl_oe),
        .wr_o(wr_o), .we_n(we_n), .we_oe(we_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] sel_exp(input int sp, input bit act);
        logic [2:0] s;
        s = 3'b111;
        if (act) s[2 - sp] = 1'b0;
        return s;
    endfunction

    // One bus cycle with a given number of ready-low samples
    task automatic run_cycle(input bit wr, input int sp, input logic [15:0] a,
                             input logic [15:0] wd, input int waits, input logic [15:0] rd);
        int strobes;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_space = sp[1:0];
        req_addr = a; req_wdata = wd; data_i = rd;
        ready_i = (waits == 0);
        @(negedge clk);
        req_valid = 0; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
        chk(busy == 1, "R12 busy after accept", busy, 1);
        chk({prog_sel_n, data_sel_n, io_sel_n} == sel_exp(sp, 1), "R2 select in setup",
            {prog_sel_n, data_sel_n, io_sel_n}, sel_exp(sp, 1));
        chk(strobe_n == 1, "R3 setup strobe high", strobe_n, 1);
        chk(addr_o == a, "R1 setup address", addr_o, a);
        chk(rw_o == !wr && wr_o == wr, "R5 direction in setup", {rw_o, wr_o}, {!wr, wr});
        chk(we_n == 1 && data_oe == 0, "R7 no drive in setup", {we_n, data_oe}, 2'b10);
        @(negedge clk);
        strobes = 1;
        chk(strobe_n == 0, "R6 strobe low", strobe_n, 0);
        chk(we_n == !wr && data_oe == wr, "R7 we and drive start", {we_n, data_oe}, {!wr, wr});
        if (wr) chk(data_o == wd, "R7 write data", data_o, wd);
        chk(addr_o == a, "R12 address held despite input change", addr_o, a);
        for (int k = 0; k < waits; k++) begin
            @(negedge clk);
            if (!strobe_n) strobes++;
            if (k == waits - 1) begin
                data_i = rd; ready_i = 1;
            end else begin
                data_i = ~rd;
            end
        end
        chk(strobes == waits + 1, "R4 strobe length", strobes, waits + 1);
        @(negedge clk);
        ready_i = 1;
        chk(strobe_n == 1 && busy == 0, "R3 cycle end", {strobe_n, busy}, 2'b10);
        chk({prog_sel_n, data_sel_n, io_sel_n} == 3'b111, "R2 idle selects",
            {prog_sel_n, data_sel_n, io_sel_n}, 3'b111);
        chk(rw_o == 1 && wr_o == 0, "R5 idle direction", {rw_o, wr_o}, 2'b10);
        chk(rd_valid == !wr, "R11 read valid pulse", rd_valid, !wr);
        if (!wr) chk(rd_data == rd, "R11 read data", rd_data, rd);
        chk(we_n == 1 && data_oe == wr, "R7 data tail after we rise", {we_n, data_oe}, {1'b1, wr});
        if (wr) chk(data_o == wd, "R7 tail data", data_o, wd);
        @(negedge clk);
        chk(rd_valid == 0, "R11 pulse one clock", rd_valid, 0);
        chk(data_oe == 0, "R8 data float idle", data_oe, 0);
    endtask

    task automatic t_reset();
        #1;
        chk(ctl_oe == 0 && we_oe == 0 && data_oe == 0, "R10 float in reset",
            {ctl_oe, we_oe, data_oe}, 3'b000);
        chk(addr_oe == 1, "R9 address driven in reset", addr_oe, 1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && strobe_n == 1 && {prog_sel_n, data_sel_n, io_sel_n} == 3'b111,
            "R2 reset idle", {busy, strobe_n}, 2'b01);
        chk(ctl_oe == 1 && we_oe == 1, "R10 driven after reset", {ctl_oe, we_oe}, 2'b11);
    endtask

    task automatic t_bad_space();
        @(negedge clk);
        req_valid = 1; req_space = 2'd3; req_addr = 16'h5A5A;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 0 && strobe_n == 1, "R13 code 3 ignored", {busy, strobe_n}, 2'b01);
        @(negedge clk);
        chk(strobe_n == 1 && {prog_sel_n, data_sel_n, io_sel_n} == 3'b111,
            "R13 no selects", {prog_sel_n, data_sel_n, io_sel_n}, 3'b111);
    endtask

    task automatic t_float();
        @(negedge clk);
        float_n = 0;
        #1;
        chk({addr_oe, ctl_oe, we_oe, data_oe} == 4'b0000, "R9 R10 emulation float",
            {addr_oe, ctl_oe, we_oe, data_oe}, 0);
        @(negedge clk);
        float_n = 1;
        #1;
        chk(addr_oe == 1 && ctl_oe == 1, "R9 float release", {addr_oe, ctl_oe}, 2'b11);
    endtask

    task automatic t_float_write();
        @(negedge clk);
        req_valid = 1; req_write = 1; req_space = 2'd1; req_addr = 16'h0100;
        req_wdata = 16'hCAFE; ready_i = 0;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(data_oe == 1, "R7 drive during wait", data_oe, 1);
        float_n = 0;
        #1;
        chk(data_oe == 0 && we_oe == 0, "R8 float overrides write drive", {data_oe, we_oe}, 2'b00);
        float_n = 1; ready_i = 1;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 0, "R12 idle after write", busy, 0);
    endtask

    task automatic t_pwr_down(input logic [15:0] last_a);
        @(negedge clk);
        pwr_down = 1;
        #1;
        chk(addr_oe == 1 && addr_o == last_a, "R9 address held in power-down", addr_o, last_a);
        chk(ctl_oe == 0 && we_oe == 1 && data_oe == 0, "R10 power-down float groups",
            {ctl_oe, we_oe, data_oe}, 3'b010);
        chk(busy == 1, "R12 busy in power-down", busy, 1);
        req_valid = 1; req_space = 2'd0; req_write = 0; req_addr = 16'h7777;
        @(negedge clk);
        req_valid = 0;
        pwr_down = 0;
        #1;
        chk(busy == 0 && strobe_n == 1 && addr_o == last_a, "R12 no accept in power-down",
            addr_o, last_a);
    endtask

    initial begin
        t_reset();
        run_cycle(0, 0, 16'h1234, 16'h0000, 0, 16'hBEEF);
        run_cycle(1, 1, 16'h2345, 16'hA5C3, 0, 16'h0000);
        run_cycle(0, 2, 16'hFFFF, 16'h0000, 1, 16'h0F0F);
        run_cycle(1, 2, 16'h0000, 16'h8001, 3, 16'h0000);
        run_cycle(0, 1, 16'h8000, 16'h0000, 5, 16'h1357);
        t_bad_space();
        t_float();
        t_float_write();
        run_cycle(1, 0, 16'h4242, 16'h6789, 2, 16'h0000);
        t_pwr_down(16'h4242);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule